// File: doc/BRIEF.md
# Command Readiness Gate for a Clocked Memory Device

This block decides when a synchronous memory device may accept read and write commands. Two separate conditions must both hold. The first is a stabilisation interval: the input clock has to run without interruption for a fixed time after power-on. The second is a lock interval: once the DLL enable is high, a fixed number of input clock cycles must pass. The first interval is needed only once per power-on reset. The second is lost, and must be met again, whenever the DLL enable goes low or the input clock stops.

All logic runs on a free-running reference time base. The input clock and the DLL enable are brought into that domain through synchronisers. A gap monitor counts reference ticks between rising input-clock edges and declares the clock stopped when the gap reaches a threshold. The stabilisation interval and the stop threshold are given as counts of reference ticks. With a 5 ns reference, 4000 ticks give 20 µs and 6 ticks give 30 ns. The lock interval is given as a count of input-clock edges. The block drives a ready flag, and a sticky flag that records any read or write request seen while the device was not ready.

Top module: `rdygate_top`

## Requirements
- R1: During and directly after power-on reset (`rst_n` low), `cmd_ready` and `cmd_early_err` are both 0.
- R2: After reset, `cmd_ready` stays 0 until the input clock has run without a stop for INIT_TICKS reference ticks. With the defaults this is 4000 ticks, which is 20 µs at 5 ns per tick.
- R3: `cmd_ready` cannot rise until LOCK_EDGES rising input-clock edges (default 2048) have been counted while the synchronised DLL enable was high and the clock was running.
- R4: When `dll_en` goes low, the lock condition is cleared. `cmd_ready` falls within SYNC_STAGES+2 reference ticks, and a full lock count restarts when `dll_en` returns high.
- R5: When no rising input-clock edge arrives for STOP_TICKS reference ticks (default 6, which is 30 ns), the clock counts as stopped. The lock condition is cleared, `cmd_ready` falls, and a full lock count restarts once edges resume.
- R6: The stabilisation interval is met only once per power-on reset. Re-locking after a DLL disable or a clock stop does not wait for it again.
- R7: `cmd_ready` is 1 only when both the stabilisation interval and the lock interval are satisfied. Either one alone keeps it 0.
- R8: If `rd_req` or `wr_req` is 1 on a reference edge while `cmd_ready` is 0, `cmd_early_err` is 1 from the next edge on. Requests made while `cmd_ready` is 1 leave it at 0.
- R9: `cmd_early_err` stays 1 until power-on reset. That reset also re-arms both the stabilisation interval and the lock interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference time base; all state is clocked on it |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| kclk | input | 1 | Input clock of the memory device, sampled through a synchroniser |
| dll_en | input | 1 | DLL enable level, sampled through a synchroniser |
| rd_req | input | 1 | Read request, valid in the reference domain |
| wr_req | input | 1 | Write request, valid in the reference domain |
| cmd_ready | output | 1 | Commands may be issued |
| cmd_early_err | output | 1 | Sticky: a request was seen while not ready |

## Verification
The input clock and the DLL enable each pass through SYNC_STAGES flops, and the edge and timer logic adds one more. As a result, `cmd_ready` falls between 3 and SYNC_STAGES+STOP_TICKS+2 reference ticks after a DLL disable or a clock stop. It rises about INIT_TICKS, or LOCK_EDGES input periods, plus a few synchroniser ticks after the stimulus. `cmd_early_err` follows a request by exactly one tick. The bench drives its inputs one nanosecond after a rising edge and samples there. Each check is placed either well before the earliest due cycle, where the old value is expected, or well after the latest one, where the new value is expected. With a 4-tick input period, the bench uses margins of at least 100 ticks around the counted intervals and 10 to 20 ticks around the fall latencies, so no check lands on an uncertain cycle.

// File: rtl/rdygate_pkg.sv
// Package: shared types and helpers for the command readiness gate.
// Assumes: nothing beyond IEEE 1800-2017.
package rdygate_pkg;

    // Status of the input clock as seen in the reference domain.
    typedef struct packed {
        logic seen;    // at least one rising edge since reset
        logic alive;   // an edge arrived within the stop threshold
        logic rise;    // single-tick pulse per rising input edge
    } kmon_t;

    // Width needed to hold values 0..n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rdygate_sync.sv
// Module: multi-flop level synchroniser into the reference domain.
// Assumes: the input is a level or a clock slow enough to be sampled;
// STAGES >= 1. Output latency is STAGES reference ticks.
module rdygate_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 1) begin : g_single
            logic stage_q;
            // Purpose: capture the asynchronous input in a single flop.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= RESET_VAL;
                else        stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            // Purpose: shift the input through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
            assign q = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rdygate_clk_mon.sv
// Module: input clock edge detector and stop monitor.
// Finds rising edges of the synchronised input clock and counts
// reference ticks since the last one. Once the gap reaches STOP_TICKS
// the clock is reported as not alive.
// Assumes: the input clock period is at least three reference ticks and
// shorter than STOP_TICKS ticks.
module rdygate_clk_mon
    import rdygate_pkg::*;
#(
    parameter int STOP_TICKS = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  kclk_s,
    output kmon_t status
);

    localparam int GW = cnt_width(STOP_TICKS);
    localparam logic [GW-1:0] GAP_MAX = GW'(STOP_TICKS);

    logic          prev_q;
    logic          seen_q;
    logic [GW-1:0] gap_q;
    logic          rise;

    assign rise = kclk_s & ~prev_q;

    // Purpose: remember the last sampled clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= kclk_s;
    end

    // Purpose: count ticks since the last rising edge, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= GAP_MAX;
            seen_q <= 1'b0;
        end else if (rise) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != GAP_MAX) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    assign status.seen  = seen_q;
    assign status.alive = seen_q && (gap_q < GAP_MAX);
    assign status.rise  = rise;

endmodule

// File: rtl/rdygate_init_timer.sv
// Module: one-time power-up stabilisation timer.
// Counts reference ticks while the input clock is alive; a stop before
// completion restarts the count. Once done, it stays done until reset.
// Assumes: INIT_TICKS >= 1.
module rdygate_init_timer #(
    parameter int INIT_TICKS = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_alive,
    output logic init_done
);

    localparam int CW = rdygate_pkg::cnt_width(INIT_TICKS);
    localparam logic [CW-1:0] LAST = CW'(INIT_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Purpose: run the stabilisation count and latch completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (!clk_alive) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign init_done = done_q;

endmodule

// File: rtl/rdygate_lock_timer.sv
// Module: DLL lock interval timer.
// Counts rising input-clock edges while the DLL enable is high and the
// clock is alive. A disable or a clock stop clears the count and the
// done flag, so a full interval is needed again.
// Assumes: LOCK_EDGES >= 1; dll_en_s is already synchronised.
module rdygate_lock_timer #(
    parameter int LOCK_EDGES = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dll_en_s,
    input  logic clk_alive,
    input  logic clk_rise,
    output logic lock_done
);

    localparam int CW = rdygate_pkg::cnt_width(LOCK_EDGES);
    localparam logic [CW-1:0] LAST = CW'(LOCK_EDGES - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          rearm;

    assign rearm = !dll_en_s || !clk_alive;

    // Purpose: count qualifying edges and hold lock until it is lost.
    always_ff @(posedge clk) begin
        if (!rst_n || rearm) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (clk_rise && !done_q) begin
            if (cnt_q == LAST) done_q <= 1'b1;
            else               cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign lock_done = done_q;

endmodule

// File: rtl/rdygate_top.sv
// Module: command readiness gate, top level.
// Combines the one-time stabilisation timer and the re-armable lock
// timer into a ready flag, and flags any request made while not ready.
// Assumes: ref_clk is free running and several times faster than kclk;
// rd_req and wr_req are already in the ref_clk domain.
module rdygate_top
    import rdygate_pkg::*;
#(
    parameter int INIT_TICKS  = 4000,
    parameter int STOP_TICKS  = 6,
    parameter int LOCK_EDGES  = 2048,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic kclk,
    input  logic dll_en,
    input  logic rd_req,
    input  logic wr_req,
    output logic cmd_ready,
    output logic cmd_early_err
);

    logic  kclk_s;
    logic  dll_s;
    kmon_t kstat;
    logic  init_done;
    logic  lock_done;
    logic  err_q;

    rdygate_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_kclk_sync (
        .clk(ref_clk), .rst_n(rst_n), .d(kclk), .q(kclk_s)
    );

    rdygate_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_dll_sync (
        .clk(ref_clk), .rst_n(rst_n), .d(dll_en), .q(dll_s)
    );

    rdygate_clk_mon #(.STOP_TICKS(STOP_TICKS)) u_clk_mon (
        .clk(ref_clk), .rst_n(rst_n), .kclk_s(kclk_s), .status(kstat)
    );

    rdygate_init_timer #(.INIT_TICKS(INIT_TICKS)) u_init (
        .clk(ref_clk), .rst_n(rst_n), .clk_alive(kstat.alive),
        .init_done(init_done)
    );

    rdygate_lock_timer #(.LOCK_EDGES(LOCK_EDGES)) u_lock (
        .clk(ref_clk), .rst_n(rst_n), .dll_en_s(dll_s),
        .clk_alive(kstat.alive), .clk_rise(kstat.rise),
        .lock_done(lock_done)
    );

    assign cmd_ready = init_done & lock_done;

    // Purpose: latch any request seen while the device is not ready.
    always_ff @(posedge ref_clk) begin
        if (!rst_n)                             err_q <= 1'b0;
        else if ((rd_req || wr_req) && !cmd_ready) err_q <= 1'b1;
    end

    assign cmd_early_err = err_q;

endmodule

// File: rtl/rdygate_checker.sv
// Module: temporal properties of the readiness gate, bound to the top.
module rdygate_checker (
    input logic ref_clk,
    input logic rst_n,
    input logic rd_req,
    input logic wr_req,
    input logic cmd_ready,
    input logic cmd_early_err,
    input logic init_done,
    input logic lock_done,
    input logic dll_s,
    input logic alive
);

    // R1: reset leaves the ready flag low on the following edge
    p_reset_clear_r1: assert property (@(posedge ref_clk)
        !rst_n |=> !cmd_ready && !cmd_early_err);

    // R6: the stabilisation condition never drops once met
    p_init_sticky_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R4: a low synchronised enable removes lock on the next edge
    p_dll_low_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !dll_s |=> !lock_done);

    // R5: a stopped clock removes lock on the next edge
    p_stop_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !alive |=> !lock_done);

    // R3: lock appears only after a cycle with enable high and clock alive
    p_lock_qual_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(lock_done) |-> $past(dll_s) && $past(alive));

    // R8: an early request sets the error flag
    p_err_set_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ((rd_req || wr_req) && !cmd_ready) |=> cmd_early_err);

    // R8: the error flag rises only after an early request
    p_err_cause_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(cmd_early_err) |-> $past((rd_req || wr_req) && !cmd_ready));

    // R9: the error flag is held until reset
    p_err_sticky_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        cmd_early_err |=> cmd_early_err);

endmodule

bind rdygate_top rdygate_checker u_rdygate_checker (
    .ref_clk(ref_clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .cmd_ready(cmd_ready), .cmd_early_err(cmd_early_err),
    .init_done(init_done), .lock_done(lock_done),
    .dll_s(dll_s), .alive(kstat.alive)
);

// File: tb/rdygate_top_bench.sv
`timescale 1ns/1ps
module rdygate_top_bench;

    localparam int INIT_T = 4000;
    localparam int STOP_T = 6;
    localparam int LOCK_E = 256;

    logic ref_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic kclk    = 1'b0;
    logic dll_en  = 1'b0;
    logic rd_req  = 1'b0;
    logic wr_req  = 1'b0;
    logic kclk_run = 1'b0;
    logic cmd_ready;
    logic cmd_early_err;

    int errors = 0;
    int checks = 0;
    int kph    = 0;
    bit finished = 1'b0;

    rdygate_top #(
        .INIT_TICKS(INIT_T), .STOP_TICKS(STOP_T),
        .LOCK_EDGES(LOCK_E), .SYNC_STAGES(2)
    ) u_rdygate_top (
        .ref_clk(ref_clk), .rst_n(rst_n), .kclk(kclk), .dll_en(dll_en),
        .rd_req(rd_req), .wr_req(wr_req),
        .cmd_ready(cmd_ready), .cmd_early_err(cmd_early_err)
    );

    // 200 MHz reference: 5 ns period
    always #2.5 ref_clk = ~ref_clk;

    // Input clock: period of 4 reference ticks (20 ns), changed on falling edges
    always @(negedge ref_clk) begin
        if (kclk_run) begin
            kph  = (kph + 1) % 4;
            kclk = (kph >= 2);
        end
    end

    typedef struct packed {
        logic        run;
        logic        dll;
        logic        rd;
        logic        wr;
        logic [31:0] ticks;
        logic        exp_rdy;
        logic        exp_err;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 32'd50,   1'b0, 1'b0}, // R7: no clock, no enable
        '{1'b1, 1'b1, 1'b0, 1'b0, 32'd3900, 1'b0, 1'b0}, // R2: stabilisation not over
        '{1'b1, 1'b1, 1'b0, 1'b0, 32'd200,  1'b1, 1'b0}, // R2/R3: both met
        '{1'b1, 1'b1, 1'b1, 1'b0, 32'd5,    1'b1, 1'b0}, // R8: read while ready
        '{1'b1, 1'b1, 1'b0, 1'b0, 32'd5,    1'b1, 1'b0}, // R8: still clean
        '{1'b1, 1'b0, 1'b0, 1'b0, 32'd10,   1'b0, 1'b0}, // R4: enable dropped
        '{1'b1, 1'b1, 1'b0, 1'b0, 32'd900,  1'b0, 1'b0}, // R4/R3: relocking
        '{1'b1, 1'b1, 1'b0, 1'b0, 32'd200,  1'b1, 1'b0}, // R6: no second stabilisation
        '{1'b0, 1'b1, 1'b0, 1'b0, 32'd20,   1'b0, 1'b0}, // R5: clock stopped
        '{1'b1, 1'b1, 1'b0, 1'b0, 32'd900,  1'b0, 1'b0}, // R5: relock pending
        '{1'b1, 1'b1, 1'b0, 1'b0, 32'd200,  1'b1, 1'b0}, // R5/R6: relocked
        '{1'b0, 1'b1, 1'b0, 1'b1, 32'd20,   1'b0, 1'b1}, // R8: write while not ready
        '{1'b1, 1'b1, 1'b0, 1'b0, 32'd1200, 1'b1, 1'b1}  // R9: error held
    };

    task automatic tick(input int n);
        repeat (n) @(posedge ref_clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5ns * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        tick(4);
        check("R1", "ready in reset", cmd_ready, 1'b0);
        check("R1", "err in reset", cmd_early_err, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            kclk_run = VEC[i].run;
            dll_en   = VEC[i].dll;
            rd_req   = VEC[i].rd;
            wr_req   = VEC[i].wr;
            tick(int'(VEC[i].ticks));
            check($sformatf("R-vec%0d", i), "ready", cmd_ready, VEC[i].exp_rdy);
            check($sformatf("R-vec%0d", i), "err", cmd_early_err, VEC[i].exp_err);
        end
        rd_req = 1'b0;
        wr_req = 1'b0;

        // R9: reset while running clears both flags and re-arms stabilisation
        rst_n = 1'b0;
        tick(3);
        check("R9", "ready after reset", cmd_ready, 1'b0);
        check("R9", "err after reset", cmd_early_err, 1'b0);
        rst_n = 1'b1;
        tick(2000);
        check("R9", "ready waits for stabilisation again", cmd_ready, 1'b0);
        tick(2200);
        check("R2", "ready after stabilisation", cmd_ready, 1'b1);

        // R8: a one-tick read while ready leaves the flag clear
        rd_req = 1'b1;
        tick(1);
        rd_req = 1'b0;
        tick(2);
        check("R8", "read while ready", cmd_early_err, 1'b0);

        // R8: a one-tick read while not ready sets the flag on the next edge
        dll_en = 1'b0;
        tick(10);
        check("R4", "ready after disable", cmd_ready, 1'b0);
        rd_req = 1'b1;
        tick(1);
        rd_req = 1'b0;
        check("R8", "early read", cmd_early_err, 1'b1);
        tick(5);
        check("R9", "err held", cmd_early_err, 1'b1);

        finish_run();
    end

endmodule